// File: doc/BRIEF.md
# Shift-Loaded RAM Address Counter

This block generates the 16-bit address for a 64 KB external RAM. It is built so that a small microcontroller can drive it with only a few pins. The address register is split into four 4-bit counter stages. All stages share one load strobe and one count enable.

The two lowest stages take their load data from the 8-bit bus that also runs to the RAM data pins. Each higher stage takes its load data from the stage two places below it. As a result, one load pulse moves the current low byte up into the high byte while the bus value enters the low byte. To set a full address, the controller presents the high byte and pulses load, then presents the low byte and pulses load again. After that, a single count-enable line steps through consecutive addresses, and the carry ripples from one nibble to the next.

The block also makes the active-low RAM output-enable and write-enable strobes. Each strobe is gated by the low half of the clock, so every access cycle gives exactly one pulse. The bus is only an input to this block and is never driven by it, which leaves it free for the RAM during reads. All pins are plain control and data levels. There is no valid/ready handshake, because a value is taken on every edge where load is high and nothing can push back.

Top module: `shift_addr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `ram_addr` becomes 0x0000. While `rst` is high, `ram_oe_n` and `ram_we_n` stay high whatever the other inputs are.
- R2: On a rising edge with `load` high, `ram_addr[7:0]` takes `bus_in`, and `ram_addr[15:8]` takes the previous `ram_addr[7:0]`.
- R3: Two load pulses, first with byte H and then with byte L on `bus_in`, leave `ram_addr` equal to {H, L}.
- R4: On a rising edge with `count_en` high and `load` low, `ram_addr` increases by one. The carry passes across each 4-bit stage boundary (0x00FF→0x0100, 0x0FFF→0x1000).
- R5: Counting from 0xFFFF gives 0x0000.
- R6: When `load` and `count_en` are both high, the load acts and no increment is added.
- R7: With `load` and `count_en` both low, `ram_addr` keeps its value.
- R8: `ram_oe_n` is low only while `clk` is low, `rd_en` is high, `wr_en` is low and `rst` is low. It is high during the high half of the clock.
- R9: `ram_we_n` is low only while `clk` is low, `wr_en` is high and `rst` is low. When `rd_en` and `wr_en` are both high, only `ram_we_n` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Its low half gates the RAM strobes |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Shared load strobe for all four stages |
| count_en | input | 1 | Shared count enable for all four stages |
| bus_in | input | 8 | Shared data bus, seen as input only |
| rd_en | input | 1 | Request a RAM read strobe this cycle |
| wr_en | input | 1 | Request a RAM write strobe this cycle |
| ram_addr | output | 16 | Address to the RAM |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The load path is tried with a single pulse and with a two-pulse address set using distinct byte values. These show that the old low byte, and not the bus, reaches the high byte. Counting starts from 0x00FF, 0x0FFF and 0xFFFF. Each start value exercises a different depth of nibble carry, so a broken link at any stage boundary, or in the wrap, gives a different result. The strobes are sampled in both clock halves for read only, write only and both together, and with reset held. This separates phase gating errors from errors in the request priority.

// File: rtl/addrctr_pkg.sv
package addrctr_pkg;
  parameter int unsigned NIB_W    = 4;
  parameter int unsigned NUM_NIBS = 4;
  parameter int unsigned BUS_W    = 8;
endpackage

// File: rtl/addrctr_nibble.sv
module addrctr_nibble #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= ld_data;
    else if (step) q <= q + 1'b1;
  end
endmodule

// File: rtl/addrctr_strobe.sv
module addrctr_strobe (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_en,
  output logic oe_n,
  output logic we_n
);
  logic low_phase;

  assign low_phase = ~clk & ~rst;
  assign we_n = ~(low_phase & wr_en);
  assign oe_n = ~(low_phase & rd_en & ~wr_en);
endmodule

// File: rtl/shift_addr_counter.sv
module shift_addr_counter
  import addrctr_pkg::*;
#(
  parameter int unsigned P_NIB_W    = NIB_W,
  parameter int unsigned P_NUM_NIBS = NUM_NIBS,
  parameter int unsigned P_BUS_W    = BUS_W,
  localparam int unsigned ADDR_W    = P_NIB_W * P_NUM_NIBS,
  localparam int unsigned BUS_NIBS  = P_BUS_W / P_NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              count_en,
  input  logic [P_BUS_W-1:0] bus_in,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic [P_NIB_W-1:0] nib_q [P_NUM_NIBS];
  logic [P_NUM_NIBS-1:0] step;

  for (genvar i = 0; i < P_NUM_NIBS; i++) begin : g_stage
    logic [P_NIB_W-1:0] src;

    if (i < BUS_NIBS) begin : g_from_bus
      assign src = bus_in[i*P_NIB_W +: P_NIB_W];
    end else begin : g_from_below
      assign src = nib_q[i-BUS_NIBS];
    end

    if (i == 0) begin : g_step_first
      assign step[i] = count_en;
    end else begin : g_step_chain
      assign step[i] = step[i-1] & (&nib_q[i-1]);
    end

    addrctr_nibble #(.W(P_NIB_W)) u_nib (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (step[i]),
      .ld_data (src),
      .q       (nib_q[i])
    );

    assign ram_addr[i*P_NIB_W +: P_NIB_W] = nib_q[i];
  end

  addrctr_strobe u_strobe (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .oe_n  (ram_oe_n),
    .we_n  (ram_we_n)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ram_addr == '0); // R1

  AST_LOAD_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    load |=> ram_addr == {$past(ram_addr[ADDR_W-P_BUS_W-1:0]), $past(bus_in)}); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (count_en && !load) |=> ram_addr == $past(ram_addr) + 1'b1); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !load) |=> $stable(ram_addr)); // R7
endmodule

// File: tb/shift_addr_counter_tb_top.sv
`timescale 1ns/1ps
module shift_addr_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic        count_en = 1'b0;
  logic [7:0]  bus_in = 8'h00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] ram_addr;
  logic        ram_oe_n;
  logic        ram_we_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_addr_counter dut_i (
    .clk(clk), .rst(rst), .load(load), .count_en(count_en), .bus_in(bus_in),
    .rd_en(rd_en), .wr_en(wr_en), .ram_addr(ram_addr),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_addr(input string tag, input logic [15:0] exp);
    chk(ram_addr === exp, tag, int'(ram_addr), int'(exp));
  endtask

  task automatic pulse_load(input logic [7:0] b);
    @(posedge clk); #2;
    bus_in = b; load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  task automatic run_count(input int n);
    @(posedge clk); #2;
    count_en = 1'b1;
    for (int k = 0; k < n; k++) @(posedge clk);
    #1 count_en = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    pulse_load(a[15:8]);
    pulse_load(a[7:0]);
  endtask

  task automatic t_reset;
    rst = 1'b1; rd_en = 1'b1; wr_en = 1'b1; load = 1'b1; count_en = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk_addr("R1 reset addr", 16'h0000);
    @(negedge clk); #1;
    chk(ram_oe_n === 1'b1, "R1 oe_n in reset", int'(ram_oe_n), 1);
    chk(ram_we_n === 1'b1, "R1 we_n in reset", int'(ram_we_n), 1);
    @(posedge clk); #2;
    rst = 1'b0; rd_en = 1'b0; wr_en = 1'b0; load = 1'b0; count_en = 1'b0;
  endtask

  task automatic t_load_shift;
    pulse_load(8'h3C);
    chk_addr("R2 first load", 16'h003C);
    pulse_load(8'hA5);
    chk_addr("R2 shift low to high", 16'h3CA5);
  endtask

  task automatic t_full_addr;
    set_addr(16'h5E71);
    chk_addr("R3 two-byte address", 16'h5E71);
    set_addr(16'hC209);
    chk_addr("R3 second address", 16'hC209);
  endtask

  task automatic t_count_carry;
    set_addr(16'h00FE);
    run_count(2);
    chk_addr("R4 carry into nibble 2", 16'h0100);
    set_addr(16'h0FFF);
    run_count(1);
    chk_addr("R4 carry into nibble 3", 16'h1000);
    set_addr(16'h1234);
    run_count(5);
    chk_addr("R4 plain count", 16'h1239);
  endtask

  task automatic t_wrap;
    set_addr(16'hFFFF);
    run_count(1);
    chk_addr("R5 wrap", 16'h0000);
  endtask

  task automatic t_priority;
    set_addr(16'h4410);
    @(posedge clk); #2;
    bus_in = 8'h77; load = 1'b1; count_en = 1'b1;
    @(posedge clk); #1;
    load = 1'b0; count_en = 1'b0;
    chk_addr("R6 load over count", 16'h1077);
  endtask

  task automatic t_hold;
    set_addr(16'h9ABC);
    @(posedge clk); #2 bus_in = 8'h11;
    repeat (3) @(posedge clk);
    #1 chk_addr("R7 idle hold", 16'h9ABC);
  endtask

  task automatic t_strobes;
    @(posedge clk); #2 rd_en = 1'b1;
    @(negedge clk); #1;
    chk(ram_oe_n === 1'b0, "R8 oe_n low phase", int'(ram_oe_n), 0);
    chk(ram_we_n === 1'b1, "R9 we_n idle on read", int'(ram_we_n), 1);
    @(posedge clk); #1;
    chk(ram_oe_n === 1'b1, "R8 oe_n high phase", int'(ram_oe_n), 1);
    rd_en = 1'b0; wr_en = 1'b1;
    @(negedge clk); #1;
    chk(ram_we_n === 1'b0, "R9 we_n low phase", int'(ram_we_n), 0);
    @(posedge clk); #1;
    chk(ram_we_n === 1'b1, "R9 we_n high phase", int'(ram_we_n), 1);
    rd_en = 1'b1;
    @(negedge clk); #1;
    chk(ram_we_n === 1'b0, "R9 write wins we_n", int'(ram_we_n), 0);
    chk(ram_oe_n === 1'b1, "R9 write wins oe_n", int'(ram_oe_n), 1);
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk); #1;
    chk(ram_oe_n === 1'b1, "R8 oe_n idle", int'(ram_oe_n), 1);
  endtask

  task automatic t_reset_override;
    set_addr(16'h2468);
    @(posedge clk); #2;
    rst = 1'b1; load = 1'b1; count_en = 1'b1; bus_in = 8'hEE; rd_en = 1'b1;
    @(negedge clk); #1;
    chk(ram_oe_n === 1'b1, "R1 oe_n held by reset", int'(ram_oe_n), 1);
    @(posedge clk); #1;
    chk_addr("R1 reset over load", 16'h0000);
    rst = 1'b0; load = 1'b0; count_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_shift();
    t_full_addr();
    t_count_carry();
    t_wrap();
    t_priority();
    t_hold();
    t_strobes();
    t_reset_override();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule